// File: doc/BRIEF.md
# UART Receive Character Queue

This block is the buffer between the receive shift logic of a UART and the host side that reads received characters. Each time the shift logic completes a character it pushes one entry: eight data bits plus three status flags (parity error, framing error, break). The host pops entries one at a time and sees the oldest entry on the head outputs, together with that entry's own flags.

The queue runs in one of two modes, selected by `fifo_en`. With the queue enabled it holds up to 16 entries, raises a trigger flag at a selectable fill level, and runs a character timeout. With the queue disabled it behaves as a single holding register, and a new character replaces an unread one. In both modes a lost or replaced character raises a one-cycle overrun pulse. A summary flag reports whether any stored entry carries an error flag. A self-clearing clear input empties the queue without losing a character that completes in the same cycle.

An occupancy controller with three named states drives the storage. **EMPTY** holds no entry. **PARTIAL** holds at least one entry and has room for more. **FULL** holds as many entries as the current mode allows. The transitions are these. *fill* moves from EMPTY to PARTIAL, or to FULL when the capacity is one. *top-up* moves from PARTIAL to FULL. *drain* moves from FULL to PARTIAL and from PARTIAL to EMPTY. *swap* keeps FULL, either by replacing the entry in single mode or by a push and pop in the same cycle. *flush* moves any state to EMPTY, or to the one-entry state when a push arrives in the same cycle.

Top module: `uart_rx_queue`

## Requirements
- R1: After reset the queue is empty and `data_ready`, `trig_hit`, `overrun`, `err_any`, `timeout`, `rd_data` and the head flags are all 0.
- R2: With `fifo_en`=1 up to 16 entries are stored and popped oldest first. `rd_data`, `head_perr`, `head_ferr` and `head_brk` show the oldest entry's data and flags, and read 0 while the queue is empty.
- R3: `data_ready` is 1 exactly when at least one entry is stored. It changes in the cycle after the push or pop that changes the count.
- R4: With `fifo_en`=1, `trig_hit` is 1 when the stored count is at least the level chosen by `trig_sel`: 2'b00 gives 1, 2'b01 gives 4, 2'b10 gives 8 and 2'b11 gives 14. With `fifo_en`=0, `trig_hit` equals `data_ready`.
- R5: With `fifo_en`=1, a push into a full queue without a pop in the same cycle is discarded. The 16 stored entries are unchanged, and `overrun` is 1 for the one cycle after that push.
- R6: With `fifo_en`=0 the capacity is one entry. A push while an entry is unread and not popped in the same cycle replaces it, and `overrun` is 1 for the one cycle after that push.
- R7: A push and a pop in the same cycle on a full queue are both performed, with no overrun.
- R8: A `rx_clear` pulse empties the queue at the next edge. A push in that same cycle is kept as the only entry.
- R9: Any change of `fifo_en` empties the queue in the same way as `rx_clear`.
- R10: `err_any` is 1 while at least one stored entry, at any position, has a parity, framing or break flag set.
- R11: With `fifo_en`=1 and the queue non-empty, `timeout` becomes 1 once four `char_tick` strobes have arrived with no push, pop or clear. It returns to 0 after a pop, push or clear, and it never rises with `fifo_en`=0.
- R12: A pop while the queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1: 16-entry queue mode, 0: single holding register |
| rx_clear | input | 1 | One-cycle strobe that empties the queue |
| trig_sel | input | 2 | Trigger level select |
| push_valid | input | 1 | Completed character strobe from the shift logic |
| push_data | input | 8 | Character data |
| push_perr | input | 1 | Parity error flag of the pushed character |
| push_ferr | input | 1 | Framing error flag of the pushed character |
| push_brk | input | 1 | Break flag of the pushed character |
| rd_pop | input | 1 | Host read strobe that removes the head entry |
| char_tick | input | 1 | One strobe per character time |
| rd_data | output | 8 | Head entry data |
| head_perr | output | 1 | Head entry parity error |
| head_ferr | output | 1 | Head entry framing error |
| head_brk | output | 1 | Head entry break |
| data_ready | output | 1 | At least one entry stored |
| trig_hit | output | 1 | Fill level reached |
| overrun | output | 1 | One-cycle pulse after a discarded or replaced character |
| err_any | output | 1 | Some stored entry carries an error flag |
| timeout | output | 1 | Character timeout |

## Verification
The assertions assume that `rx_clear`, `push_valid`, `rd_pop` and `char_tick` are clean one-cycle or level strobes sampled on the clock edge. They also assume that `fifo_en` only changes while the controller is not already in the middle of a flush that the assertion about single-register capacity must span. For that reason the capacity property only applies once `fifo_en` has been steady for a cycle. The stimulus drives every input on the falling edge. It changes `fifo_en` only through complete steps, so each mode change is a single flush followed by stable operation. It covers every trigger level with full fill and drain sweeps that include overrun, simultaneous push and pop, reads on an empty queue, clears with and without a coincident push, and timer runs in both modes.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

    localparam int RXQ_DATA_W = 8;

    typedef struct packed {
        logic                  brk;
        logic                  ferr;
        logic                  perr;
        logic [RXQ_DATA_W-1:0] data;
    } rxq_entry_t;

    typedef enum logic [1:0] {
        Q_EMPTY   = 2'd0,
        Q_PARTIAL = 2'd1,
        Q_FULL    = 2'd2
    } rxq_state_e;

    typedef enum logic [1:0] {
        TRIG_ONE     = 2'b00,
        TRIG_QUARTER = 2'b01,
        TRIG_HALF    = 2'b10,
        TRIG_NEAR    = 2'b11
    } rxq_trig_e;

    // fill level for each trigger code, scaled to the queue depth
    function automatic int trig_level(input logic [1:0] sel, input int depth);
        int lvl;
        unique case (rxq_trig_e'(sel))
            TRIG_ONE:     lvl = 1;
            TRIG_QUARTER: lvl = depth / 4;
            TRIG_HALF:    lvl = depth / 2;
            TRIG_NEAR:    lvl = depth - 2;
            default:      lvl = 1;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             rx_clear,
    input  logic             push_valid,
    input  logic             rd_pop,
    output logic             do_flush,
    output logic             do_write,
    output logic             do_pop,
    output logic [CNT_W-1:0] occ,
    output rxq_state_e       state,
    output logic             overrun
);

    rxq_state_e       state_nx;
    logic [CNT_W-1:0] occ_nx;
    logic [CNT_W-1:0] cap;
    logic             mode_q;
    logic             flush;
    logic             ovr_set;

    assign cap   = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);
    assign flush = rx_clear | (fifo_en ^ mode_q);

    // next-state and command logic
    always_comb begin
        do_flush = flush;
        do_write = 1'b0;
        do_pop   = 1'b0;
        ovr_set  = 1'b0;
        occ_nx   = occ;
        if (flush) begin
            // flush: a character completing now survives
            do_write = push_valid;
            occ_nx   = push_valid ? CNT_W'(1) : '0;
        end else begin
            unique case (state)
                Q_EMPTY: begin
                    // fill; a read here is ignored
                    do_write = push_valid;
                    occ_nx   = push_valid ? CNT_W'(1) : '0;
                end
                Q_PARTIAL: begin
                    // top-up or drain
                    do_write = push_valid;
                    do_pop   = rd_pop;
                    occ_nx   = occ + CNT_W'(push_valid) - CNT_W'(rd_pop);
                end
                Q_FULL: begin
                    // swap, drain, or drop with overrun
                    do_pop   = rd_pop | (push_valid & ~fifo_en);
                    do_write = push_valid & (rd_pop | ~fifo_en);
                    ovr_set  = push_valid & ~rd_pop;
                    occ_nx   = occ - CNT_W'(rd_pop & ~push_valid);
                end
                default: begin
                    occ_nx = '0;
                end
            endcase
        end
        if (occ_nx == '0)
            state_nx = Q_EMPTY;
        else if (occ_nx >= cap)
            state_nx = Q_FULL;
        else
            state_nx = Q_PARTIAL;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= Q_EMPTY;
            occ    <= '0;
            mode_q <= 1'b0;
        end else begin
            state  <= state_nx;
            occ    <= occ_nx;
            mode_q <= fifo_en;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n)
            overrun <= 1'b0;
        else
            overrun <= ovr_set;
    end

endmodule

// File: rtl/rxq_slots.sv
module rxq_slots
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       do_flush,
    input  logic       do_write,
    input  logic       do_pop,
    input  rxq_entry_t wr_entry,
    output rxq_entry_t head,
    output logic       err_any
);

    rxq_entry_t       slot_q  [DEPTH];
    logic             valid_q [DEPTH];
    logic [DEPTH-1:0] slot_err;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] wr_addr;

    assign wr_addr = do_flush ? '0 : wr_ptr;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic wr_here;
        logic rd_here;
        assign wr_here = do_write && (wr_addr == PTR_W'(i));
        assign rd_here = do_pop && (rd_ptr == PTR_W'(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[i] <= 1'b0;
                slot_q[i]  <= '0;
            end else begin
                if (wr_here)
                    slot_q[i] <= wr_entry;
                if (do_flush)
                    valid_q[i] <= wr_here;
                else if (wr_here)
                    valid_q[i] <= 1'b1;
                else if (rd_here)
                    valid_q[i] <= 1'b0;
            end
        end

        assign slot_err[i] = valid_q[i] &
                             (slot_q[i].perr | slot_q[i].ferr | slot_q[i].brk);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else if (do_flush) begin
            wr_ptr <= do_write ? PTR_W'(1) : '0;
            rd_ptr <= '0;
        end else begin
            wr_ptr <= wr_ptr + PTR_W'(do_write);
            rd_ptr <= rd_ptr + PTR_W'(do_pop);
        end
    end

    assign head    = slot_q[rd_ptr];
    assign err_any = |slot_err;

endmodule

// File: rtl/rxq_timer.sv
module rxq_timer #(
    parameter int TO_CHARS = 4,
    localparam int TCNT_W = $clog2(TO_CHARS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic char_tick,
    output logic timeout
);

    logic [TCNT_W-1:0] tcnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            tcnt <= '0;
        else if (restart)
            tcnt <= '0;
        else if (char_tick && tcnt != TCNT_W'(TO_CHARS))
            tcnt <= tcnt + TCNT_W'(1);
    end

    assign timeout = (tcnt == TCNT_W'(TO_CHARS));

endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int TO_CHARS = 4,
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fifo_en,
    input  logic                  rx_clear,
    input  logic [1:0]            trig_sel,
    input  logic                  push_valid,
    input  logic [RXQ_DATA_W-1:0] push_data,
    input  logic                  push_perr,
    input  logic                  push_ferr,
    input  logic                  push_brk,
    input  logic                  rd_pop,
    input  logic                  char_tick,
    output logic [RXQ_DATA_W-1:0] rd_data,
    output logic                  head_perr,
    output logic                  head_ferr,
    output logic                  head_brk,
    output logic                  data_ready,
    output logic                  trig_hit,
    output logic                  overrun,
    output logic                  err_any,
    output logic                  timeout
);

    rxq_state_e       state;
    logic [CNT_W-1:0] occ;
    logic             do_flush;
    logic             do_write;
    logic             do_pop;
    rxq_entry_t       wr_entry;
    rxq_entry_t       head;
    logic             tmr_restart;
    logic [CNT_W-1:0] level;

    assign wr_entry = '{brk: push_brk, ferr: push_ferr, perr: push_perr, data: push_data};

    rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_en    (fifo_en),
        .rx_clear   (rx_clear),
        .push_valid (push_valid),
        .rd_pop     (rd_pop),
        .do_flush   (do_flush),
        .do_write   (do_write),
        .do_pop     (do_pop),
        .occ        (occ),
        .state      (state),
        .overrun    (overrun)
    );

    rxq_slots #(.DEPTH(DEPTH)) u_slots (
        .clk      (clk),
        .rst_n    (rst_n),
        .do_flush (do_flush),
        .do_write (do_write),
        .do_pop   (do_pop),
        .wr_entry (wr_entry),
        .head     (head),
        .err_any  (err_any)
    );

    assign tmr_restart = push_valid | rd_pop | do_flush | ~fifo_en | (state == Q_EMPTY);

    rxq_timer #(.TO_CHARS(TO_CHARS)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (tmr_restart),
        .char_tick (char_tick),
        .timeout   (timeout)
    );

    assign data_ready = (state != Q_EMPTY);
    assign level      = CNT_W'(trig_level(trig_sel, DEPTH));
    assign trig_hit   = fifo_en ? (occ >= level) : data_ready;

    assign rd_data   = data_ready ? head.data : '0;
    assign head_perr = data_ready & head.perr;
    assign head_ferr = data_ready & head.ferr;
    assign head_brk  = data_ready & head.brk;

endmodule

// File: rtl/uart_rx_queue_chk.sv
module uart_rx_queue_chk #(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_en,
    input logic             rx_clear,
    input logic             push_valid,
    input logic             overrun,
    input logic             data_ready,
    input logic             trig_hit,
    input logic             err_any,
    input logic             timeout,
    input logic [CNT_W-1:0] occ
);

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(DEPTH));

    assert_ready_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        data_ready == (occ != '0));

    assert_trig_needs_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trig_hit |-> data_ready);

    assert_overrun_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> $past(push_valid));

    assert_single_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && $stable(fifo_en)) |-> occ <= CNT_W'(1));

    assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rx_clear) |-> occ <= CNT_W'(1));

    assert_err_needs_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_any |-> data_ready);

    assert_timeout_needs_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> data_ready);

endmodule

bind uart_rx_queue uart_rx_queue_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_en    (fifo_en),
    .rx_clear   (rx_clear),
    .push_valid (push_valid),
    .overrun    (overrun),
    .data_ready (data_ready),
    .trig_hit   (trig_hit),
    .err_any    (err_any),
    .timeout    (timeout),
    .occ        (occ)
);

// File: tb/uart_rx_queue_test.sv
module uart_rx_queue_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b0;
    logic       rx_clear = 1'b0;
    logic [1:0] trig_sel = 2'b00;
    logic       push_valid = 1'b0;
    logic [7:0] push_data = 8'h00;
    logic       push_perr = 1'b0;
    logic       push_ferr = 1'b0;
    logic       push_brk = 1'b0;
    logic       rd_pop = 1'b0;
    logic       char_tick = 1'b0;
    logic [7:0] rd_data;
    logic       head_perr, head_ferr, head_brk;
    logic       data_ready, trig_hit, overrun, err_any, timeout;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // model state: entry = {brk, ferr, perr, data}
    logic [10:0] mq[$];
    logic        m_fe = 1'b0;
    logic        m_ovr = 1'b0;
    int          m_tcnt = 0;

    always #2 clk = ~clk;

    uart_rx_queue uut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_clear(rx_clear),
        .trig_sel(trig_sel), .push_valid(push_valid), .push_data(push_data),
        .push_perr(push_perr), .push_ferr(push_ferr), .push_brk(push_brk),
        .rd_pop(rd_pop), .char_tick(char_tick), .rd_data(rd_data),
        .head_perr(head_perr), .head_ferr(head_ferr), .head_brk(head_brk),
        .data_ready(data_ready), .trig_hit(trig_hit), .overrun(overrun),
        .err_any(err_any), .timeout(timeout)
    );

    task automatic check(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    function automatic int level_of(input logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 4 : (s == 2'd2) ? 8 : 14;
    endfunction

    task automatic compare(input string tag);
        int  sz;
        logic [10:0] hd;
        bit  anyerr;
        sz = mq.size();
        hd = (sz > 0) ? mq[0] : 11'h0;
        anyerr = 1'b0;
        foreach (mq[k]) if (mq[k][10:8] != 3'b000) anyerr = 1'b1;
        check(tag, "R3 data_ready", int'(data_ready), int'(sz > 0));
        check(tag, "R4 trig_hit", int'(trig_hit),
              m_fe ? int'(sz >= level_of(trig_sel)) : int'(sz > 0));
        check(tag, "R2 head", int'({head_brk, head_ferr, head_perr, rd_data}), int'(hd));
        check(tag, m_fe ? "R5 overrun" : "R6 overrun", int'(overrun), int'(m_ovr));
        check(tag, "R10 err_any", int'(err_any), int'(anyerr));
        check(tag, "R11 timeout", int'(timeout), int'(m_tcnt == 4));
    endtask

    // one clock of stimulus, model update, then comparison
    task automatic step(input string tag, input bit fe, input bit clr, input bit p,
                        input logic [10:0] e, input bit r, input bit t);
        bit flush;
        bit popok;
        int cap;
        int sz0;
        fifo_en = fe; rx_clear = clr; push_valid = p; rd_pop = r; char_tick = t;
        {push_brk, push_ferr, push_perr, push_data} = e;
        flush = clr || (fe != m_fe);
        sz0 = mq.size();
        // timer model uses the state before this edge
        if (p || r || flush || !fe || sz0 == 0) m_tcnt = 0;
        else if (t && m_tcnt < 4) m_tcnt++;
        m_ovr = 1'b0;
        m_fe = fe;
        cap = fe ? 16 : 1;
        if (flush) begin
            mq.delete();
            if (p) mq.push_back(e);
        end else begin
            popok = r && (sz0 > 0);
            if (popok) void'(mq.pop_front());
            if (p) begin
                if (mq.size() >= cap) begin
                    m_ovr = 1'b1;
                    if (!fe) begin
                        void'(mq.pop_front());
                        mq.push_back(e);
                    end
                end else begin
                    mq.push_back(e);
                end
            end
        end
        @(negedge clk);
        compare(tag);
        rx_clear = 1'b0; push_valid = 1'b0; rd_pop = 1'b0; char_tick = 1'b0;
    endtask

    function automatic logic [10:0] mk(input int base, input int k);
        logic [2:0] fl;
        fl = ((k % 7) == 3) ? 3'b001 : ((k % 11) == 5) ? 3'b010 : ((k % 13) == 9) ? 3'b100 : 3'b000;
        return {fl, 8'((base + k * 37) & 8'hff)};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", "data_ready", int'(data_ready), 0);
        check("R1", "trig_hit", int'(trig_hit), 0);
        check("R1", "overrun", int'(overrun), 0);
        check("R1", "err_any", int'(err_any), 0);
        check("R1", "timeout", int'(timeout), 0);
        check("R1", "head", int'({head_brk, head_ferr, head_perr, rd_data}), 0);

        // R2 R4 R5 R12: fill/overrun/drain sweep for each trigger level
        for (int s = 0; s < 4; s++) begin
            trig_sel = 2'(s);
            step("R9", 1'b1, 1'b1, 1'b0, 11'h0, 1'b0, 1'b0);
            for (int k = 0; k < 16; k++) step("R2", 1'b1, 1'b0, 1'b1, mk(s * 50, k), 1'b0, 1'b0);
            for (int k = 0; k < 2; k++) step("R5", 1'b1, 1'b0, 1'b1, mk(200, k), 1'b0, 1'b0);
            // R7: push and pop together on a full queue
            step("R7", 1'b1, 1'b0, 1'b1, mk(90, s), 1'b1, 1'b0);
            for (int k = 0; k < 16; k++) step("R2", 1'b1, 1'b0, 1'b0, 11'h0, 1'b1, 1'b0);
            step("R12", 1'b1, 1'b0, 1'b0, 11'h0, 1'b1, 1'b0);
            step("R12", 1'b1, 1'b0, 1'b0, 11'h0, 1'b1, 1'b1);
        end

        // R10: error entry deep in the queue, then drained past
        step("R10", 1'b1, 1'b0, 1'b1, 11'h011, 1'b0, 1'b0);
        step("R10", 1'b1, 1'b0, 1'b1, 11'h422, 1'b0, 1'b0);
        step("R10", 1'b1, 1'b0, 1'b1, 11'h033, 1'b0, 1'b0);
        for (int k = 0; k < 3; k++) step("R10", 1'b1, 1'b0, 1'b0, 11'h0, 1'b1, 1'b0);

        // R8: clear with and without a coincident push
        for (int k = 0; k < 5; k++) step("R8", 1'b1, 1'b0, 1'b1, mk(7, k), 1'b0, 1'b0);
        step("R8", 1'b1, 1'b1, 1'b1, 11'h2A5, 1'b0, 1'b0);
        step("R8", 1'b1, 1'b0, 1'b1, 11'h05A, 1'b0, 1'b0);
        step("R8", 1'b1, 1'b1, 1'b0, 11'h0, 1'b0, 1'b0);

        // R11: timeout runs, cleared by read, push and clear
        trig_sel = 2'b11;
        step("R11", 1'b1, 1'b0, 1'b1, 11'h041, 1'b0, 1'b0);
        step("R11", 1'b1, 1'b0, 1'b1, 11'h042, 1'b0, 1'b0);
        for (int k = 0; k < 6; k++) step("R11", 1'b1, 1'b0, 1'b0, 11'h0, 1'b0, 1'b1);
        step("R11", 1'b1, 1'b0, 1'b0, 11'h0, 1'b1, 1'b0);
        for (int k = 0; k < 5; k++) step("R11", 1'b1, 1'b0, 1'b0, 11'h0, 1'b0, (k % 2) == 0);
        for (int k = 0; k < 4; k++) step("R11", 1'b1, 1'b0, 1'b0, 11'h0, 1'b0, 1'b1);
        step("R11", 1'b1, 1'b0, 1'b1, 11'h043, 1'b0, 1'b0);
        for (int k = 0; k < 4; k++) step("R11", 1'b1, 1'b0, 1'b0, 11'h0, 1'b0, 1'b1);
        step("R11", 1'b1, 1'b1, 1'b0, 11'h0, 1'b0, 1'b0);

        // R9 R6: leave queue with data, switch to single mode
        for (int k = 0; k < 3; k++) step("R9", 1'b1, 1'b0, 1'b1, mk(3, k), 1'b0, 1'b0);
        step("R9", 1'b0, 1'b0, 1'b0, 11'h0, 1'b0, 1'b0);
        for (int k = 0; k < 6; k++) step("R6", 1'b0, 1'b0, 1'b1, mk(60, k), 1'b0, 1'b0);
        step("R6", 1'b0, 1'b0, 1'b1, 11'h1EE, 1'b1, 1'b0);
        for (int k = 0; k < 6; k++) step("R11", 1'b0, 1'b0, 1'b0, 11'h0, 1'b0, 1'b1);
        step("R6", 1'b0, 1'b0, 1'b0, 11'h0, 1'b1, 1'b0);
        step("R12", 1'b0, 1'b0, 1'b0, 11'h0, 1'b1, 1'b0);
        step("R8", 1'b0, 1'b1, 1'b1, 11'h0C3, 1'b0, 1'b0);
        step("R9", 1'b1, 1'b0, 1'b0, 11'h0, 1'b0, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog: got running expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule